// File: doc/BRIEF.md
# Load Switch Fault Supervisor

This block is the digital controller of a protected power load switch. It watches four synchronous inputs: an enable, an indication that the analog current limiter is active, a supply undervoltage indication and an over-temperature indication. From these it drives a switch-enable output and an active-low fault flag.

An overcurrent does not trip the switch at once. The block keeps the switch on and the flag inactive for a blanking window. If the current limit is still active when the window ends, the switch is turned off and the flag is pulled low. After a fixed restart wait, the switch is turned back on, provided that enable is still asserted. Undervoltage and over-temperature each hold the switch off and report through the same flag for as long as they are present. When either one clears, normal operation resumes on the next cycle.

Both durations are parameters counted in clock cycles. A parameter chosen at build time sets the polarity of the enable input.

Top module: `load_switch_supervisor`

## Requirements
- R1: While rst_ni is low, sw_on_o is 0 and fault_n_o is 1 (idle, switch off, no fault).
- R2: One clock edge after enable goes inactive, sw_on_o is 0 and fault_n_o is 1, from any state including a pending fault wait.
- R3: With enable active and no condition present, sw_on_o goes to 1 on the next edge and fault_n_o stays 1.
- R4: An overcurrent that lasts fewer than BLANK_CYCLES edges after the edge that first samples it keeps sw_on_o at 1 and fault_n_o at 1. If it clears, the blanking count restarts from zero.
- R5: An overcurrent still present after BLANK_CYCLES edges in blanking forces sw_on_o to 0 and fault_n_o to 0.
- R6: After a fault shutdown the outputs hold at sw_on_o 0 and fault_n_o 0 for RESTART_CYCLES edges. On the next edge, if enable is still active, sw_on_o returns to 1 and fault_n_o to 1.
- R7: An overcurrent present right after an auto-restart is given a full new blanking window of BLANK_CYCLES edges before it trips again.
- R8: Undervoltage forces sw_on_o 0 and fault_n_o 0 from the next edge for as long as it lasts, and it takes precedence over over-temperature. When it clears and nothing else is present, sw_on_o is 1 on the next edge, with no restart wait.
- R9: Over-temperature forces sw_on_o 0 and fault_n_o 0 from the next edge. When it clears, sw_on_o is 1 and fault_n_o is 1 on the next edge.
- R10: With EN_ACTIVE_HIGH = 1, en_i = 1 enables the switch. With EN_ACTIVE_HIGH = 0, en_i = 0 enables it and en_i = 1 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Switch enable; polarity set by EN_ACTIVE_HIGH |
| ilim_i | input | 1 | Current limiter active (overcurrent) |
| uvlo_i | input | 1 | Supply undervoltage |
| otemp_i | input | 1 | Die over-temperature |
| sw_on_o | output | 1 | Switch enable drive |
| fault_n_o | output | 1 | Fault flag, active low |

## Verification
The bench targets the exact edges at which blanking expires and at which the restart wait ends. A counter that is off by one would trip or restart one cycle early or late, and a check one cycle before each boundary would see the wrong outputs. The bench drops an overcurrent just before expiry and then raises it again. A design that kept the partial count would trip early, and one that kept the count across an auto-restart would trip at once after the retry. Other tests remove enable during the fault wait, overlap undervoltage with over-temperature, and clear each of them. These catch a restart that ignores enable, a lost priority, and a recovery that goes through the long restart delay when it should not.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_ON    = 3'd1,
    ST_BLANK = 3'd2,
    ST_FWAIT = 3'd3,
    ST_THERM = 3'd4,
    ST_UVLO  = 3'd5
  } lss_state_e;
endpackage

// File: rtl/lss_en_decode.sv
module lss_en_decode #(
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input  logic en_i,
  output logic en_act_o
);
  generate
    if (EN_ACTIVE_HIGH) begin : g_high
      assign en_act_o = en_i;
    end else begin : g_low
      assign en_act_o = ~en_i;
    end
  endgenerate
endmodule

// File: rtl/lss_timer.sv
module lss_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  // count only while running; any pause or expiry restarts from zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (run_i && !done_o)   cnt_q <= cnt_q + 1'b1;
    else                         cnt_q <= '0;
  end

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_pause_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/lss_fsm.sv
module lss_fsm
  import lss_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_act_i,
  input  logic ilim_i,
  input  logic uvlo_i,
  input  logic otemp_i,
  input  logic blank_done_i,
  input  logic rst_done_i,
  output logic blank_run_o,
  output logic rst_run_o,
  output logic sw_on_o,
  output logic fault_n_o
);
  lss_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en_act_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF, ST_UVLO, ST_THERM: begin
          if (uvlo_i)       state_d = ST_UVLO;
          else if (otemp_i) state_d = ST_THERM;
          else              state_d = ST_ON;
        end
        ST_ON: begin
          if (uvlo_i)       state_d = ST_UVLO;
          else if (otemp_i) state_d = ST_THERM;
          else if (ilim_i)  state_d = ST_BLANK;
        end
        ST_BLANK: begin
          if (uvlo_i)            state_d = ST_UVLO;
          else if (otemp_i)      state_d = ST_THERM;
          else if (!ilim_i)      state_d = ST_ON;
          else if (blank_done_i) state_d = ST_FWAIT;
        end
        ST_FWAIT: begin
          if (rst_done_i) begin
            if (uvlo_i)       state_d = ST_UVLO;
            else if (otemp_i) state_d = ST_THERM;
            else              state_d = ST_ON;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign blank_run_o = (state_q == ST_BLANK);
  assign rst_run_o   = (state_q == ST_FWAIT);
  assign sw_on_o     = (state_q == ST_ON) || (state_q == ST_BLANK);
  assign fault_n_o   = !((state_q == ST_FWAIT) || (state_q == ST_THERM) ||
                         (state_q == ST_UVLO));

  p_off_when_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_act_i |=> !sw_on_o && fault_n_o);

  p_blank_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ON && en_act_i && ilim_i && !uvlo_i && !otemp_i
    |=> sw_on_o && fault_n_o);

  p_trip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_done_i && en_act_i && ilim_i && !uvlo_i && !otemp_i
    |=> !sw_on_o && !fault_n_o);

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_done_i && en_act_i && !uvlo_i && !otemp_i |=> sw_on_o && fault_n_o);

  p_uvlo_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_act_i && uvlo_i |=> !sw_on_o && !fault_n_o);

  p_therm_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_act_i && otemp_i |=> !sw_on_o && !fault_n_o);
endmodule

// File: rtl/load_switch_supervisor.sv
module load_switch_supervisor #(
  parameter bit          EN_ACTIVE_HIGH = 1'b1,
  parameter int unsigned BLANK_CYCLES   = 2_500_000,
  parameter int unsigned RESTART_CYCLES = 17_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ilim_i,
  input  logic uvlo_i,
  input  logic otemp_i,
  output logic sw_on_o,
  output logic fault_n_o
);
  logic en_act, blank_run, blank_done, rst_run, rst_done;

  lss_en_decode #(.EN_ACTIVE_HIGH(EN_ACTIVE_HIGH)) u_en (
    .en_i    (en_i),
    .en_act_o(en_act)
  );

  lss_timer #(.LIMIT(BLANK_CYCLES)) u_blank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (blank_run),
    .done_o(blank_done)
  );

  lss_timer #(.LIMIT(RESTART_CYCLES)) u_restart (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (rst_run),
    .done_o(rst_done)
  );

  lss_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_act_i    (en_act),
    .ilim_i      (ilim_i),
    .uvlo_i      (uvlo_i),
    .otemp_i     (otemp_i),
    .blank_done_i(blank_done),
    .rst_done_i  (rst_done),
    .blank_run_o (blank_run),
    .rst_run_o   (rst_run),
    .sw_on_o     (sw_on_o),
    .fault_n_o   (fault_n_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !sw_on_o && fault_n_o);
endmodule

// File: tb/sim_load_switch_supervisor.sv
`timescale 1ns/1ps
module sim_load_switch_supervisor;
  localparam int B = 8;
  localparam int R = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ilim = 1'b0, uvlo = 1'b0, otemp = 1'b0;
  logic en1 = 1'b1;
  logic sw, fn, sw1, fn1;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  load_switch_supervisor #(.EN_ACTIVE_HIGH(1'b1), .BLANK_CYCLES(B),
                           .RESTART_CYCLES(R)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ilim_i(ilim), .uvlo_i(uvlo),
    .otemp_i(otemp), .sw_on_o(sw), .fault_n_o(fn));

  load_switch_supervisor #(.EN_ACTIVE_HIGH(1'b0), .BLANK_CYCLES(B),
                           .RESTART_CYCLES(R)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en1), .ilim_i(1'b0), .uvlo_i(1'b0),
    .otemp_i(1'b0), .sw_on_o(sw1), .fault_n_o(fn1));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected {sw_on, fault_n}
  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {sw,fault_n} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    en = 1'b1;
    tick(2);
    check("R1", {sw, fn}, 2'b01);
    rst_n = 1'b1;
    tick(1);
    check("R3", {sw, fn}, 2'b11);
  endtask

  task automatic t_short_ilim;
    ilim = 1'b1;
    tick(B - 1);
    check("R4", {sw, fn}, 2'b11);
    ilim = 1'b0;
    tick(1);
    check("R4", {sw, fn}, 2'b11);
    ilim = 1'b1;                 // window must restart from zero
    tick(B);
    check("R4", {sw, fn}, 2'b11);
    tick(1);
    check("R5", {sw, fn}, 2'b00);
    ilim = 1'b0;
    tick(R - 1);
    check("R6", {sw, fn}, 2'b00);
    tick(1);
    check("R6", {sw, fn}, 2'b11);
  endtask

  task automatic t_retrip;
    ilim = 1'b1;
    tick(B + 1);
    check("R5", {sw, fn}, 2'b00);
    tick(R);
    check("R6", {sw, fn}, 2'b11);
    tick(B);
    check("R7", {sw, fn}, 2'b11);
    tick(1);
    check("R7", {sw, fn}, 2'b00);
    en = 1'b0;                   // drop enable during fault wait
    tick(1);
    check("R2", {sw, fn}, 2'b01);
    tick(R + 2);
    check("R2", {sw, fn}, 2'b01);
    ilim = 1'b0;
    en = 1'b1;
    tick(1);
    check("R3", {sw, fn}, 2'b11);
  endtask

  task automatic t_uvlo_otemp;
    uvlo = 1'b1;
    otemp = 1'b1;
    tick(1);
    check("R8", {sw, fn}, 2'b00);
    uvlo = 1'b0;
    tick(1);
    check("R9", {sw, fn}, 2'b00);
    otemp = 1'b0;
    tick(1);
    check("R9", {sw, fn}, 2'b11);
    uvlo = 1'b1;
    tick(5);
    check("R8", {sw, fn}, 2'b00);
    uvlo = 1'b0;
    tick(1);
    check("R8", {sw, fn}, 2'b11);
    otemp = 1'b1;
    tick(1);
    check("R9", {sw, fn}, 2'b00);
    en = 1'b0;
    tick(1);
    check("R2", {sw, fn}, 2'b01);
    otemp = 1'b0;
    en = 1'b1;
    tick(1);
    check("R3", {sw, fn}, 2'b11);
  endtask

  task automatic t_polarity;
    check("R10", {sw1, fn1}, 2'b01);
    en1 = 1'b0;
    tick(1);
    check("R10", {sw1, fn1}, 2'b11);
    en1 = 1'b1;
    tick(1);
    check("R10", {sw1, fn1}, 2'b01);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_short_ilim();
    t_retrip();
    t_uvlo_otemp();
    t_polarity();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule